// File: doc/BRIEF.md
# SPI Controller with Single-Wire Bidirectional Mode

This block is a byte-wide serial peripheral interface controller that can be the clock master or a selected slave. A small register bus sets it up and moves data: two control registers, a status register and a data register. As master, writing the data register sends one byte and receives one byte at the same time. The serial clock runs at a fixed fraction of the system clock. When the byte completes, the received value is held for reading, a completion flag is raised, and an interrupt can be requested.

Normally the block uses separate data-out and data-in pins. A mode bit switches it to a single shared data wire. As master, the shared wire is the MOSI pad. As slave, it is the MISO pad. The other data pad is released and never driven. A per-pad direction bit decides whether the shared pad drives or listens. An open-drain option makes every serial output only pull low or float.

All pad inputs (`sck_i`, `ss_n_i`, `mosi_i`, `miso_i`) are taken to be synchronous to `clk` and slower than it. The block has no input synchronisers.

Top module: `spi_bidir_ctrl`

## Requirements
- R1: After reset the control register reads 0x04, the mode register reads 0x00 and the status register reads 0x00. `irq` is low and no pad output enable is high.
- R2: Register addresses: 0 is control, 1 is mode, 2 is status (read only), 3 is data. Control register fields:
  - bit 7: interrupt enable
  - bit 6: block enable
  - bit 5: open-drain outputs
  - bit 4: master select
  - bit 3: clock polarity (CPOL)
  - bit 2: clock phase (CPHA)
  - bit 1: slave-select output enable
  - bit 0: LSB first

  Mode register fields: bit 0 is shared-wire mode, bit 1 is the MOSI pad direction (1 = drive), bit 2 is the MISO pad direction. The unused mode bits read 0. Status register fields: bit 7 is transfer complete, bit 4 is mode fault.
- R3: As master with the block enabled, writing the data register while no transfer runs starts an 8-bit transfer. The serial clock idles at CPOL and toggles every CLK_DIV system clocks, 16 times in all. The complete flag is set on the clock edge CLK_DIV*16 cycles after the write edge, and the received byte then reads from the data register.
- R4: With CPHA=0, each bit is on the data output before the leading clock edge, the input is sampled on the leading edge, and the output changes after the trailing edge. With CPHA=1, the output changes on the leading edge and the input is sampled on the trailing edge. This holds for both CPOL values.
- R5: With LSB first set, bit 0 of the byte is sent and received first. Otherwise bit 7 is first.
- R6: Accessing the data register alone leaves the complete flag set. A status read that sees the flag set, followed by a data register read or write, clears it.
- R7: As enabled master with slave-select output disabled, a low on `ss_n_i` sets the mode-fault flag. A status read that sees the flag set, followed by a control register write, clears it.
- R8: `irq` is high exactly while interrupt enable is 1 and the complete or mode-fault flag is set.
- R9: In normal mode, the master drives SCK and MOSI and never MISO. An enabled slave drives MISO only while `ss_n_i` is low, and never MOSI.
- R10: In shared-wire mode as master, MOSI output enable equals the MOSI direction bit, received data comes from `mosi_i`, and MISO is never driven.
- R11: In shared-wire mode as slave, MISO output enable equals the MISO direction bit, received data comes from `miso_i`, and MOSI is never driven.
- R12: With open-drain set, no serial output (SCK, MOSI, MISO) is ever enabled while its value is 1. A high level comes from the pad pull-up, and transfers still carry correct data.
- R13: As an enabled slave with `ss_n_i` low, the block shifts one bit per external clock cycle using the same CPOL, CPHA and bit-order rules. The byte loaded through the data register is sent. After eight trailing edges the received byte and the complete flag appear.
- R14: As master with slave-select output enabled, `ss_n_oe` is high, and `ss_n_o` is low during a transfer and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (drives flag-clear side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock pad value |
| sck_oe | output | 1 | Serial clock pad output enable |
| sck_i | input | 1 | Serial clock pad input (slave) |
| ss_n_o | output | 1 | Slave-select pad value |
| ss_n_oe | output | 1 | Slave-select pad output enable |
| ss_n_i | input | 1 | Slave-select pad input |
| mosi_o | output | 1 | MOSI pad value |
| mosi_oe | output | 1 | MOSI pad output enable |
| mosi_i | input | 1 | MOSI pad input |
| miso_o | output | 1 | MISO pad value |
| miso_oe | output | 1 | MISO pad output enable |
| miso_i | input | 1 | MISO pad input |

## Verification
The in-design properties watch every cycle for these rules:
- open-drain never drives a 1
- shared-wire mode never enables both data pads
- the master clock rests at CPOL when idle
- a start always leads to a busy transfer
- a masked interrupt stays low
- the mode-fault condition sets its flag

Only the bench scenarios can show the rest:
- correct bytes in both directions for all four clock modes and both bit orders
- the exact completion cycle
- the two-step flag clearing
- which pad carries received data in shared-wire mode

// File: rtl/spi_bidir_ctrl.sv
module spi_bidir_ctrl #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       ss_n_o,
  output logic       ss_n_oe,
  input  logic       ss_n_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_MODE = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

  logic [7:0] ctrl, sr, rxbuf, shifted;
  logic [2:0] mode;
  logic [DW-1:0] divcnt;
  logic [3:0] bitcnt;
  logic busy, sck_lvl, rbit, dout, spif, modf, arm_f, arm_m, sck_q;

  logic spie, spe, wom, mstr, cpol, cpha, ssoe, lsbf, bidir, dir_mosi, dir_miso;
  assign {spie, spe, wom, mstr, cpol, cpha, ssoe, lsbf} = ctrl;
  assign {dir_miso, dir_mosi, bidir} = mode;

  logic wr_ctrl, wr_mode, wr_data, rd_stat, data_acc, start, mtick, sedge;
  logic lead, trail, last, rx_in, out_bit, tx_bit, smp, clr_f, mf;

  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign wr_mode  = reg_we && reg_addr == A_MODE;
  assign wr_data  = reg_we && reg_addr == A_DATA;
  assign rd_stat  = reg_re && reg_addr == A_STAT;
  assign data_acc = (reg_re || reg_we) && reg_addr == A_DATA;
  assign start    = wr_data && spe && mstr && !busy;
  assign mtick    = busy && divcnt == DIV_LAST;
  assign sedge    = spe && !mstr && !ss_n_i && (sck_i != sck_q);
  assign lead     = mstr ? (mtick && !sck_lvl) : (sedge && (sck_i != cpol));
  assign trail    = mstr ? (mtick && sck_lvl)  : (sedge && (sck_i == cpol));
  assign last     = trail && bitcnt == 4'd7;
  assign rx_in    = (bidir ~^ mstr) ? mosi_i : miso_i;
  assign out_bit  = lsbf ? sr[0] : sr[7];
  assign tx_bit   = cpha ? dout : out_bit;
  assign smp      = cpha ? rx_in : rbit;
  assign shifted  = lsbf ? {smp, sr[7:1]} : {sr[6:0], smp};
  assign clr_f    = arm_f && data_acc;
  assign mf       = spe && mstr && !ssoe && !ss_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 8'h04; mode <= '0; sr <= '0; rxbuf <= '0; divcnt <= '0; bitcnt <= '0;
      busy <= 1'b0; sck_lvl <= 1'b0; rbit <= 1'b0; dout <= 1'b0; sck_q <= 1'b0;
      spif <= 1'b0; modf <= 1'b0; arm_f <= 1'b0; arm_m <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (wr_ctrl) ctrl <= reg_wdata;
      if (wr_mode) mode <= reg_wdata[2:0];
      if (busy) divcnt <= mtick ? '0 : divcnt + DW'(1);
      if (mtick) sck_lvl <= !sck_lvl;
      if (lead) begin
        if (cpha) dout <= out_bit;
        else      rbit <= rx_in;
      end
      if (trail) begin
        sr <= shifted;
        bitcnt <= bitcnt + 4'd1;
      end
      if (last) begin
        bitcnt <= '0;
        rxbuf <= shifted;
        busy <= 1'b0;
      end
      if (!mstr && ss_n_i) bitcnt <= '0;
      if (!spe) begin
        busy <= 1'b0;
        sck_lvl <= 1'b0;
      end
      if (start) begin
        sr <= reg_wdata; busy <= 1'b1; divcnt <= '0; sck_lvl <= 1'b0; bitcnt <= '0;
      end else if (wr_data && !mstr && bitcnt == 4'd0) begin
        sr <= reg_wdata;
      end
      if (rd_stat && spif) arm_f <= 1'b1;
      else if (clr_f)      arm_f <= 1'b0;
      if (last)       spif <= 1'b1;
      else if (clr_f) spif <= 1'b0;
      if (rd_stat && modf) arm_m <= 1'b1;
      else if (wr_ctrl)    arm_m <= 1'b0;
      if (mf)                      modf <= 1'b1;
      else if (arm_m && wr_ctrl)   modf <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_MODE:  reg_rdata = {5'b0, mode};
      A_STAT:  reg_rdata = {spif, 2'b0, modf, 4'b0};
      default: reg_rdata = rxbuf;
    endcase
  end

  assign irq = spie && (spif || modf);

  logic mosi_en, miso_en, sck_en, sck_val;
  assign mosi_en = spe && mstr && (!bidir || dir_mosi);
  assign miso_en = spe && !mstr && (bidir ? dir_miso : !ss_n_i);
  assign sck_en  = spe && mstr;
  assign sck_val = cpol ^ sck_lvl;

  assign mosi_o  = !wom && tx_bit;
  assign mosi_oe = mosi_en && (!wom || !tx_bit);
  assign miso_o  = !wom && tx_bit;
  assign miso_oe = miso_en && (!wom || !tx_bit);
  assign sck_o   = !wom && sck_val;
  assign sck_oe  = sck_en && (!wom || !sck_val);
  assign ss_n_o  = !busy;
  assign ss_n_oe = spe && mstr && ssoe;

  a_r12_never_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    wom |-> !((mosi_oe && mosi_o) || (miso_oe && miso_o) || (sck_oe && sck_o)));
  a_r10_one_shared_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (spe && bidir) |-> !(mosi_oe && miso_oe));
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (spe && mstr && !busy && !wom) |-> (sck_o == cpol));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !spie |-> !irq);
  a_r7_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mf |=> modf);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (spif && !clr_f) |=> spif);
endmodule

// File: tb/spi_bidir_ctrl_test.sv
module spi_bidir_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int H = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_we = 0, reg_re = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, sck_o, sck_oe, ss_n_o, ss_n_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic mosi_i, miso_i;
  logic m_sck = 0, m_ss = 1, m_mosi = 0, m_miso = 0;
  int route = 0;

  logic cfg_spie = 0, cfg_spe = 0, cfg_wom = 0, cfg_mstr = 0, cfg_cpol = 0, cfg_cpha = 1;
  logic cfg_ssoe = 0, cfg_lsbf = 0, cfg_bidir = 0, cfg_dmosi = 0, cfg_dmiso = 0;

  logic [7:0] p_tx = 0, p_rx = 0;
  logic p_bit = 0, p_prev = 0;
  int p_idx = 8, p_req = 0, p_seen = 0;

  int tests = 0, fails = 0, oe_err = 0, wom_err = 0;

  logic sck_pad, mosi_pad, miso_pad;
  assign sck_pad  = sck_oe  ? sck_o  : (cfg_wom ? 1'b1 : sck_o);
  assign mosi_pad = mosi_oe ? mosi_o : 1'b1;
  assign miso_pad = miso_oe ? miso_o : 1'b1;
  assign mosi_i = (route == 1) ? mosi_pad : (route == 2 ? p_bit : m_mosi);
  assign miso_i = (route == 0) ? p_bit : m_miso;

  spi_bidir_ctrl #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(m_sck),
    .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe), .ss_n_i(m_ss),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bpos(int k);
    return cfg_lsbf ? k : 7 - k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // partner slave model for master transfers
  always @(negedge clk) begin : partner
    logic cur;
    cur = sck_pad;
    if (p_req != p_seen) begin
      p_seen = p_req; p_idx = 0; p_rx = 0; p_bit = p_tx[bpos(0)];
    end else if (cur != p_prev && p_idx < 8) begin
      if (cur != cfg_cpol) begin
        if (!cfg_cpha) p_rx[bpos(p_idx)] = mosi_pad;
        else           p_bit = p_tx[bpos(p_idx)];
      end else begin
        if (cfg_cpha) p_rx[bpos(p_idx)] = mosi_pad;
        p_idx++;
        if (!cfg_cpha && p_idx < 8) p_bit = p_tx[bpos(p_idx)];
      end
    end
    p_prev = cur;
  end

  // per-cycle reference for pad enables (R9, R10, R11) and open drain (R12)
  always @(negedge clk) begin : padref
    logic e_mo, e_mi, e_sk;
    #2;
    if (rst_n) begin
      e_mo = cfg_spe && cfg_mstr && (!cfg_bidir || cfg_dmosi);
      e_mi = cfg_spe && !cfg_mstr && (cfg_bidir ? cfg_dmiso : !m_ss);
      e_sk = cfg_spe && cfg_mstr;
      if (!cfg_wom && (mosi_oe !== e_mo || miso_oe !== e_mi || sck_oe !== e_sk)) oe_err++;
      if (cfg_wom && ((mosi_oe && mosi_o) || (miso_oe && miso_o) || (sck_oe && sck_o))) wom_err++;
      if (cfg_wom && ((mosi_oe && !e_mo) || (miso_oe && !e_mi) || (sck_oe && !e_sk))) oe_err++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; reg_re = 1; #1 v = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic setup(input logic [7:0] c, input logic [2:0] m);
    wr(2'd0, c);
    {cfg_spie, cfg_spe, cfg_wom, cfg_mstr, cfg_cpol, cfg_cpha, cfg_ssoe, cfg_lsbf} = c;
    m_sck = c[3];
    wr(2'd1, {5'b0, m});
    {cfg_dmiso, cfg_dmosi, cfg_bidir} = m;
    @(negedge clk);
  endtask

  task automatic finish_byte(input string tag, input logic [7:0] exp_rx);
    logic [7:0] v;
    peek(2'd2, v);
    check({tag, " R3 complete flag"}, v[7], 1);
    check({tag, " R8 irq follows enable"}, irq, cfg_spie);
    rd(2'd3, v);
    check({tag, " received byte"}, v, exp_rx);
    peek(2'd2, v);
    check({tag, " R6 data access alone keeps flag"}, v[7], 1);
    rd(2'd2, v);
    rd(2'd3, v);
    peek(2'd2, v);
    check({tag, " R6 flag cleared"}, v[7], 0);
    check({tag, " R8 irq drops"}, irq, 0);
  endtask

  task automatic master_xfer(input string tag, input logic [7:0] tx, input logic [7:0] ptx);
    logic [7:0] v;
    p_tx = ptx; p_req++;
    repeat (2) @(negedge clk);
    if (!cfg_wom) check({tag, " R3 clock idles at CPOL"}, sck_o, cfg_cpol);
    wr(2'd3, tx);
    repeat (8 * DIV) @(negedge clk);
    if (cfg_ssoe) begin
      check({tag, " R14 select enabled"}, ss_n_oe, 1);
      check({tag, " R14 select low in transfer"}, ss_n_o, 0);
    end
    repeat (8 * DIV - 1) @(negedge clk);
    peek(2'd2, v);
    check({tag, " R3 not complete one cycle early"}, v[7], 0);
    @(negedge clk);
    peek(2'd2, v);
    check({tag, " R3 complete on exact cycle"}, v[7], 1);
    repeat (2) @(negedge clk);
    if (cfg_ssoe) check({tag, " R14 select high after"}, ss_n_o, 1);
    finish_byte(tag, route == 1 ? tx : ptx);
    if (route == 0) check({tag, " R4 partner received"}, p_rx, tx);
  endtask

  task automatic slave_xfer(input string tag, input logic [7:0] dtx, input logic [7:0] mtx, input bit shared);
    logic [7:0] mrx;
    mrx = 0;
    wr(2'd3, dtx);
    check({tag, " R9 MISO quiet while deselected"}, miso_oe, 0);
    m_ss = 0;
    repeat (H) @(negedge clk);
    if (shared) check({tag, " R11 MISO follows direction 0"}, miso_oe, 0);
    else        check({tag, " R9 MISO driven when selected"}, miso_oe, 1);
    check({tag, " R9 slave never drives MOSI"}, mosi_oe, 0);
    for (int k = 0; k < 8; k++) begin
      int p;
      p = bpos(k);
      if (!cfg_cpha) begin
        if (shared) m_miso = mtx[p]; else m_mosi = mtx[p];
        repeat (H) @(negedge clk);
        mrx[p] = miso_pad;
        m_sck = ~cfg_cpol;
        repeat (H) @(negedge clk);
        m_sck = cfg_cpol;
      end else begin
        m_sck = ~cfg_cpol;
        if (shared) m_miso = mtx[p]; else m_mosi = mtx[p];
        repeat (H) @(negedge clk);
        mrx[p] = miso_pad;
        m_sck = cfg_cpol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    m_ss = 1;
    repeat (2) @(negedge clk);
    finish_byte({tag, " R13"}, mtx);
    if (!shared) check({tag, " R13 slave sent byte"}, mrx, dtx);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(2'd0, v); check("R1 control reset", v, 8'h04);
    peek(2'd1, v); check("R1 mode reset", v, 8'h00);
    peek(2'd2, v); check("R1 status reset", v, 8'h00);
    check("R1 irq reset", irq, 0);
    check("R1 no pad enabled", {sck_oe, ss_n_oe, mosi_oe, miso_oe}, 0);

    wr(2'd0, 8'hA5);
    peek(2'd0, v); check("R2 control readback", v, 8'hA5);
    wr(2'd1, 8'hFF);
    peek(2'd1, v); check("R2 mode readback keeps three bits", v, 8'h07);
    setup(8'h04, 3'b000);

    route = 0;
    for (int m = 0; m < 8; m++) begin
      logic [7:0] c;
      c = 8'h50 | 8'((m >> 1) & 3) << 2 | 8'(m & 1);
      setup(c, 3'b000);
      master_xfer($sformatf("R4/R5 cpol%0d cpha%0d lsbf%0d", c[3], c[2], c[0]),
                  8'h3C ^ 8'(m * 37), 8'hC5 ^ 8'(m * 91));
    end

    setup(8'hD2, 3'b000);
    master_xfer("R14 R8 select output with irq", 8'h81, 8'h7E);

    setup(8'h71, 3'b000);
    master_xfer("R12 open drain", 8'h96, 8'h2B);

    route = 1;
    setup(8'h54, 3'b011);
    check("R10 shared MOSI drives", mosi_oe, 1);
    check("R10 MISO released", miso_oe, 0);
    master_xfer("R10 shared loopback", 8'hA7, 8'h00);

    route = 2;
    setup(8'h51, 3'b001);
    check("R10 shared MOSI as input", mosi_oe, 0);
    master_xfer("R10 shared receive on MOSI", 8'h5A, 8'hE1);

    route = 3;
    setup(8'h40, 3'b000);
    slave_xfer("R4 slave cpha0", 8'hB4, 8'h69, 0);
    setup(8'h4D, 3'b000);
    slave_xfer("R5 slave cpha1 lsbf", 8'h1E, 8'hD3, 0);
    setup(8'h44, 3'b001);
    slave_xfer("R11 shared slave", 8'h33, 8'hC9, 1);

    setup(8'hD4, 3'b000);
    m_ss = 0;
    repeat (2) @(negedge clk);
    m_ss = 1;
    @(negedge clk);
    peek(2'd2, v); check("R7 mode fault set", v[4], 1);
    check("R8 irq on fault", irq, 1);
    wr(2'd0, 8'hD4);
    peek(2'd2, v); check("R7 write alone keeps fault", v[4], 1);
    rd(2'd2, v);
    wr(2'd0, 8'hD4);
    peek(2'd2, v); check("R7 fault cleared", v[4], 0);
    check("R8 irq after fault clear", irq, 0);

    check("R9 R10 R11 pad enables every cycle", oe_err, 0);
    check("R12 no high drive in open drain", wom_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule